// File: doc/BRIEF.md
# Overtemperature Alert with Fault Queue

This block watches a stream of signed temperature results and decides when an overtemperature alert pin should be driven. Each result that arrives with its valid strobe is compared against one of two programmable thresholds, chosen by the current phase. While the block is cool it compares against the upper limit; a fault is a result at or above that limit. While it is hot it compares against the hysteresis limit; a fault is a result strictly below that limit. A fault queue counts consecutive faults. When the count reaches the selected depth, an event occurs. The event flips the phase and clears the queue.

The alert can work in one of two modes. In comparator mode the pin simply follows the phase, so it stays asserted from the rise event until the fall event. In interrupt mode each event sets a latch, and a status-read strobe clears it. Because the phase keeps alternating, the next event after an overtemperature event is a drop below hysteresis. A polarity bit chooses whether the asserted pin level is high or low.

Both limits arrive as 16-bit words. The temperature sits in the upper 12 bits in two's complement, scaled at 1/16 °C per step, and the low 4 bits are ignored. The package provides the reset values of the two limits: +80 °C (16'h5000) for the upper limit and +75 °C (16'h4B00) for hysteresis.

Top module: `okt_alert`

## Requirements
- R1: After a synchronous active-low reset the block is in the cool phase with an empty queue and no latched event, so `alert_pin` is at its inactive level (1 when `cfg[1]`=0, 0 when `cfg[1]`=1).
- R2: In the cool phase a valid sample is a fault when it is greater than or equal to `lim_over[15:4]`, taken as a signed value. `lim_over[3:0]` has no effect.
- R3: `cfg[3:2]` selects how many consecutive faults make an event: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6.
- R4: A valid sample that is not a fault empties the queue. A cycle without `smp_valid` leaves the queue and the pin unchanged.
- R5: With `cfg[0]`=0 (comparator mode) the pin is asserted from the cycle after the rise event. In the hot phase a fault is a valid sample strictly below `lim_hyst[15:4]`, and the pin is released the cycle after the selected number of such samples.
- R6: With `cfg[0]`=1 (interrupt mode) each event sets a latch that drives the pin. A `stat_rd` pulse clears the latch on the next cycle, unless an event occurs in that same cycle, in which case the latch stays set. After an overtemperature event, the next event is a drop below hysteresis.
- R7: `cfg[1]` selects polarity: 0 means the pin is low when asserted, 1 means the pin is high when asserted.
- R8: All comparisons are signed, so negative limits and negative samples order correctly (for example, +1 °C is above a −10 °C limit).
- R9: Each event occurs on the same clock edge that accepts the sample completing the queue, so the pin changes in the cycle right after that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A new temperature result is present |
| smp_temp | input | 12 | Signed temperature, 1/16 °C per step |
| lim_over | input | 16 | Overtemperature limit word (upper 12 bits used) |
| lim_hyst | input | 16 | Hysteresis limit word (upper 12 bits used) |
| cfg | input | 4 | [3:2] queue depth code, [1] polarity, [0] interrupt mode |
| stat_rd | input | 1 | Status-read strobe that clears the latched event |
| alert_pin | output | 1 | Alert pin level |

## Verification
The bench builds the block with its default parameters: a 12-bit temperature inside a 16-bit word, and the queue-depth set {1, 2, 4, 6}. The deepest queue is only six samples, so every depth code can be completed and broken within a short vector table. Both phases, both modes and both polarities can be crossed in one continuous run. The 12-bit width also lets the bench reach the sign boundary directly, by driving negative limits and near-zero samples.

// File: rtl/okt_pkg.sv
// Package: shared types and constants for the overtemperature alert.
// Assumes temperatures use two's complement at 1/16 degree per step.
package okt_pkg;

    // Default temperature width and limit word width.
    localparam int unsigned TEMP_W_DEF = 12;
    localparam int unsigned WORD_W_DEF = 16;

    // Reset values of the limit words: +80 C and +75 C.
    localparam logic [15:0] LIM_OVER_RST = 16'h5000;
    localparam logic [15:0] LIM_HYST_RST = 16'h4B00;

    // Alert phase: cool means watching the upper limit, hot means watching hysteresis.
    typedef enum logic {
        PH_COOL = 1'b0,
        PH_HOT  = 1'b1
    } okt_phase_t;

    // Decoded configuration nibble.
    typedef struct packed {
        logic [1:0] qsel;
        logic       pol_high;
        logic       intr_mode;
    } okt_cfg_t;

    // Largest of the four queue depths.
    function automatic int unsigned okt_max4(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/okt_window.sv
// Module: threshold window comparator.
// Picks the upper limit in the cool phase (fault when sample >= limit) or the
// hysteresis limit in the hot phase (fault when sample < limit). Limits are
// taken from the top TEMP_W bits of each word and compared as signed values.
module okt_window
    import okt_pkg::*;
#(
    parameter int unsigned TEMP_W = TEMP_W_DEF,
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic [WORD_W-1:0] lim_over,
    input  logic [WORD_W-1:0] lim_hyst,
    input  okt_phase_t        phase,
    output logic              fault
);

    localparam int unsigned PAD_W = WORD_W - TEMP_W;

    logic signed [TEMP_W-1:0] t_s;
    logic signed [TEMP_W-1:0] over_s;
    logic signed [TEMP_W-1:0] hyst_s;
    logic                     at_or_above;
    logic                     below_hyst;

    // Extract signed operands; the low PAD_W bits of each word are dropped.
    always_comb begin
        t_s    = signed'(smp_temp);
        over_s = signed'(lim_over[WORD_W-1 -: TEMP_W]);
        hyst_s = signed'(lim_hyst[WORD_W-1 -: TEMP_W]);
    end

    // Signed comparisons against both limits.
    always_comb begin
        at_or_above = (t_s >= over_s);
        below_hyst  = (t_s <  hyst_s);
    end

    // Choose the comparison that matters for the present phase.
    always_comb begin
        fault = (phase == PH_HOT) ? below_hyst : at_or_above;
    end

    // Width sanity check made at elaboration.
    initial begin
        a_r2_width_fit: assert (PAD_W < WORD_W && TEMP_W > 1)
            else $error("okt_window: TEMP_W must fit inside WORD_W");
    end

endmodule

// File: rtl/okt_fault_queue.sv
// Module: consecutive-fault counter.
// Counts valid faulting samples and raises trip on the edge that accepts the
// sample completing the selected depth; any valid non-fault sample empties it.
// Assumes every DEPTHS entry is at least 1.
module okt_fault_queue
    import okt_pkg::*;
#(
    parameter int unsigned DEPTHS [4] = '{1, 2, 4, 6}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       fault,
    input  logic [1:0] qsel,
    output logic       trip
);

    localparam int unsigned DMAX = okt_max4(DEPTHS[0], DEPTHS[1], DEPTHS[2], DEPTHS[3]);
    localparam int unsigned CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] depth;

    // Decode the selected depth from the parameter table.
    always_comb begin
        depth = CW'(DEPTHS[qsel]);
    end

    // Next count, and trip once the selected depth is reached.
    always_comb begin
        cnt_inc = cnt_q + CW'(1);
        trip    = smp_valid && fault && (cnt_inc >= depth);
    end

    // Update the queue on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (smp_valid) begin
            if (!fault || trip) cnt_q <= '0;
            else                cnt_q <= cnt_inc;
        end
    end

    // R3: the queue never holds a full largest depth.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DMAX));

    // R4: a valid non-fault sample empties the queue.
    a_r4_clear_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !fault) |=> (cnt_q == '0));

    // R4: cycles without a sample leave the queue alone.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(cnt_q));

endmodule

// File: rtl/okt_alert_ctl.sv
// Module: alert phase, interrupt latch and pin driver.
// The phase flips on every trip. The latch is set by a trip and cleared by a
// status read (a trip in the same cycle wins). The pin shows the phase in
// comparator mode or the latch in interrupt mode, with selectable polarity.
module okt_alert_ctl
    import okt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip,
    input  logic       stat_rd,
    input  logic       intr_mode,
    input  logic       pol_high,
    output okt_phase_t phase,
    output logic       alert_pin
);

    logic irq_q;
    logic asserted;

    // Phase alternates between cool and hot on each event.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= PH_COOL;
        else if (trip) phase <= (phase == PH_COOL) ? PH_HOT : PH_COOL;
    end

    // Event latch: set on trip, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (trip)    irq_q <= 1'b1;
        else if (stat_rd) irq_q <= 1'b0;
    end

    // Logical alert level for the selected mode.
    always_comb begin
        asserted = intr_mode ? irq_q : (phase == PH_HOT);
    end

    // Apply pin polarity.
    always_comb begin
        alert_pin = pol_high ? asserted : !asserted;
    end

    // R6: an event always leaves the latch set.
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> irq_q);

    // R6: a status read without a concurrent event clears the latch.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !trip) |=> !irq_q);

    // R5: the phase moves only on an event.
    a_r5_phase_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !trip |=> $stable(phase));

    // R9: an event flips the phase on the very next edge.
    a_r9_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (phase != $past(phase)));

endmodule

// File: rtl/okt_alert.sv
// Module: overtemperature alert top level.
// Joins the window comparator, the fault queue and the alert controller.
// Assumes limits arrive already stored; cfg is {qsel[1:0], pol_high, intr_mode}.
module okt_alert
    import okt_pkg::*;
#(
    parameter int unsigned TEMP_W     = TEMP_W_DEF,
    parameter int unsigned WORD_W     = WORD_W_DEF,
    parameter int unsigned DEPTHS [4] = '{1, 2, 4, 6}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic [WORD_W-1:0] lim_over,
    input  logic [WORD_W-1:0] lim_hyst,
    input  logic [3:0]        cfg,
    input  logic              stat_rd,
    output logic              alert_pin
);

    okt_cfg_t   cfg_s;
    okt_phase_t phase;
    logic       fault;
    logic       trip;

    // Unpack the configuration nibble.
    always_comb begin
        cfg_s = okt_cfg_t'(cfg);
    end

    okt_window #(
        .TEMP_W (TEMP_W),
        .WORD_W (WORD_W)
    ) u_window (
        .smp_temp (smp_temp),
        .lim_over (lim_over),
        .lim_hyst (lim_hyst),
        .phase    (phase),
        .fault    (fault)
    );

    okt_fault_queue #(
        .DEPTHS (DEPTHS)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .fault     (fault),
        .qsel      (cfg_s.qsel),
        .trip      (trip)
    );

    okt_alert_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip      (trip),
        .stat_rd   (stat_rd),
        .intr_mode (cfg_s.intr_mode),
        .pol_high  (cfg_s.pol_high),
        .phase     (phase),
        .alert_pin (alert_pin)
    );

    // R1: the cycle after reset the pin is at its inactive level.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (alert_pin == !cfg_s.pol_high) || $changed(cfg));

endmodule

// File: tb/tb_okt_alert.sv
// Bench for okt_alert: a vector table walked by one loop, then directed tests.
module tb_okt_alert;
    import okt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [11:0] smp_temp;
    logic [15:0] lim_over;
    logic [15:0] lim_hyst;
    logic [3:0]  cfg;
    logic        stat_rd;
    logic        alert_pin;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    okt_alert dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_temp  (smp_temp),
        .lim_over  (lim_over),
        .lim_hyst  (lim_hyst),
        .cfg       (cfg),
        .stat_rd   (stat_rd),
        .alert_pin (alert_pin)
    );

    // Vector: {req[3:0], cfg[3:0], valid, temp[11:0], rd, exp_pin}
    localparam int NV = 30;
    localparam logic [22:0] VEC [NV] = '{
        {4'd2, 4'b0000, 1'b1, 12'h4FF, 1'b0, 1'b1}, // R2 just below limit
        {4'd2, 4'b0000, 1'b1, 12'h500, 1'b0, 1'b0}, // R2 reaching limit trips (q1)
        {4'd5, 4'b0000, 1'b1, 12'h4B0, 1'b0, 1'b0}, // R5 equal to hysteresis holds
        {4'd5, 4'b0000, 1'b1, 12'h4AF, 1'b0, 1'b1}, // R5 below hysteresis releases
        {4'd5, 4'b0000, 1'b1, 12'h4FF, 1'b0, 1'b1}, // R5 cool again
        {4'd3, 4'b0100, 1'b1, 12'h500, 1'b0, 1'b1}, // R3 q2 first fault
        {4'd4, 4'b0100, 1'b1, 12'h4FF, 1'b0, 1'b1}, // R4 pass empties queue
        {4'd4, 4'b0100, 1'b1, 12'h600, 1'b0, 1'b1}, // R4 restart count
        {4'd4, 4'b0100, 1'b0, 12'h7FF, 1'b0, 1'b1}, // R4 no valid ignored
        {4'd3, 4'b0100, 1'b1, 12'h600, 1'b0, 1'b0}, // R3 q2 second fault trips
        {4'd3, 4'b0100, 1'b1, 12'h100, 1'b0, 1'b0}, // R3 q2 first cool sample
        {4'd9, 4'b0100, 1'b1, 12'h100, 1'b0, 1'b1}, // R9 release right after 2nd
        {4'd3, 4'b1000, 1'b1, 12'h500, 1'b0, 1'b1}, // R3 q4 1
        {4'd3, 4'b1000, 1'b1, 12'h500, 1'b0, 1'b1}, // R3 q4 2
        {4'd3, 4'b1000, 1'b1, 12'h500, 1'b0, 1'b1}, // R3 q4 3
        {4'd3, 4'b1000, 1'b1, 12'h500, 1'b0, 1'b0}, // R3 q4 4 trips
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b0}, // R3 q6 1
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b0}, // R3 q6 2
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b0}, // R3 q6 3
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b0}, // R3 q6 4
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b0}, // R3 q6 5
        {4'd3, 4'b1100, 1'b1, 12'h000, 1'b0, 1'b1}, // R3 q6 6 releases
        {4'd7, 4'b1110, 1'b0, 12'h000, 1'b0, 1'b0}, // R7 active-high idle is 0
        {4'd6, 4'b0011, 1'b1, 12'h500, 1'b0, 1'b1}, // R6 event latches
        {4'd6, 4'b0011, 1'b1, 12'h500, 1'b1, 1'b0}, // R6 read clears, hot no fault
        {4'd6, 4'b0011, 1'b1, 12'h600, 1'b0, 1'b0}, // R6 no new event while hot
        {4'd6, 4'b0011, 1'b1, 12'h4AF, 1'b0, 1'b1}, // R6 drop below hyst is event
        {4'd6, 4'b0011, 1'b0, 12'h000, 1'b1, 1'b0}, // R6 read clears
        {4'd6, 4'b0011, 1'b1, 12'h500, 1'b1, 1'b1}, // R6 event beats read
        {4'd6, 4'b0011, 1'b0, 12'h000, 1'b1, 1'b0}  // R6 later read clears
    };

    // Compare the pin with its expected level and count the result.
    task automatic check(input int req, input logic expv, input string what);
        n_run++;
        if (alert_pin !== expv) begin
            n_fail++;
            $display("FAIL R%0d %s: alert_pin=%b expected=%b", req, what, alert_pin, expv);
        end
    endtask

    // Apply one cycle of stimulus and check the pin after the edge.
    task automatic step(input logic [3:0] c, input logic v, input logic [11:0] t,
                        input logic rd, input int req, input logic expv, input string what);
        @(negedge clk);
        cfg = c; smp_valid = v; smp_temp = t; stat_rd = rd;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0; stat_rd = 1'b0;
        check(req, expv, what);
    endtask

    // Synchronous reset for three cycles.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; stat_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_temp = '0; stat_rd = 1'b0;
        cfg = 4'b0000; lim_over = LIM_OVER_RST; lim_hyst = LIM_HYST_RST;
        do_reset();
        check(1, 1'b1, "reset idle active-low");   // R1
        cfg = 4'b0010;
        #1 check(1, 1'b0, "reset idle active-high"); // R1
        cfg = 4'b0000;

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18:15], VEC[i][14], VEC[i][13:2], VEC[i][1],
                 int'(VEC[i][22:19]), VEC[i][0], $sformatf("vector %0d", i));
        end

        // R8: negative limits, signed ordering.
        do_reset();
        lim_over = 16'hF600; lim_hyst = 16'hEC00;   // -10 C and -20 C
        step(4'b0000, 1'b1, 12'hF5F, 1'b0, 8, 1'b1, "just under -10");
        step(4'b0000, 1'b1, 12'hEC0, 1'b0, 8, 1'b1, "-20 while cool");
        step(4'b0000, 1'b1, 12'h010, 1'b0, 8, 1'b0, "+1 above -10 trips");
        step(4'b0000, 1'b1, 12'hEC0, 1'b0, 8, 1'b0, "equal -20 holds");
        step(4'b0000, 1'b1, 12'hEBF, 1'b0, 8, 1'b1, "below -20 releases");

        // R2: low nibble of the limit has no effect.
        do_reset();
        lim_over = 16'h500F; lim_hyst = 16'h4B0F;
        step(4'b0000, 1'b1, 12'h500, 1'b0, 2, 1'b0, "low nibble ignored");

        // R1: reset in the middle of an alert returns to idle.
        do_reset();
        check(1, 1'b1, "reset clears active alert");
        step(4'b0100, 1'b1, 12'h500, 1'b0, 1, 1'b1, "queue empty after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule